// File: doc/BRIEF.md
# Two-Phase Processor Bus Cycle Interface

This block connects a small 8-bit processor core to its memory bus using one system clock. Each clock period is one bus cycle. The high half of the period is the address phase. The low half is the data phase. The period starts at a rising edge. At the falling edge the block registers the address that the core computed, so the address is stable for the whole data phase. At the next rising edge the block captures the byte that memory returned and hands it back to the core.

The read/write strobe comes from a double-data-rate output stage. It holds the read level for the whole address phase, and it can show a write only in the data phase. A separate output enable marks the data phase of write cycles. The outgoing write data sits on a wired-OR internal bus that reads as zero whenever no source drives it, so the block has no tri-state nets.

The core side is a request stream. Each request is `req_valid` together with its address, direction and write data. `req_ready` is high whenever reset is low, so a request that is valid before the falling edge is always taken and becomes exactly one bus cycle, with no wait states. The core may present a new request in every cycle. The response side has no back-pressure: `rsp_valid` is high for one cycle and the core must take `rsp_data` in that cycle. The response to a read appears one cycle after the request.

Top module: `two_phase_bus_if`

## Requirements
- R1: A synchronous active-high reset clears `mem_addr` to 0, `rsp_data` to 0 and `rsp_valid` to 0. While reset is high, `mem_rw_n` is 1, `mem_oe` is 0, `mem_wdata` is 0 and `req_ready` is 0.
- R2: When `req_valid` is 1 at a falling edge, `mem_addr` takes `req_addr` at that edge. It then holds that value until the next falling edge, which covers the data phase and the following address phase.
- R3: `mem_rw_n` is 1 (read) throughout every high half of the clock.
- R4: In the low half after a request is accepted, `mem_rw_n` is 0 when `req_we` was 1 and 1 when `req_we` was 0.
- R5: `mem_oe` is 1 only in the low half of a write cycle. `mem_wdata` carries the accepted write data while `mem_oe` is 1 and is 0 at all other times.
- R6: For a read cycle, the block captures `mem_rdata` at the rising edge that ends the data phase. From that edge, `rsp_valid` is 1 for exactly one cycle, with `rsp_data` equal to the captured byte. After a write cycle or an idle cycle, `rsp_valid` is 0 and `rsp_data` keeps its previous value.
- R7: When `req_valid` is 0 at a falling edge, the next cycle has no bus activity. `mem_addr` holds its value, `mem_rw_n` stays 1 and `mem_oe` stays 0.
- R8: `req_ready` is 1 whenever reset is low. Requests in consecutive cycles each produce their own bus cycle. A write followed at once by a read of the same address returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; high half = address phase, low half = data phase |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present for this cycle |
| req_ready | output | 1 | Request accepted (high whenever not in reset) |
| req_we | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W (16) | Next bus address from the core |
| req_wdata | input | DATA_W (8) | Write data from the core |
| rsp_valid | output | 1 | One-cycle pulse: read data returned |
| rsp_data | output | DATA_W (8) | Captured read byte |
| mem_addr | output | ADDR_W (16) | Address registered on the falling edge |
| mem_rw_n | output | 1 | Read/write strobe, 0 = write, valid in the low half only |
| mem_oe | output | 1 | Write-data output enable, low half of write cycles |
| mem_wdata | output | DATA_W (8) | Write data to memory, 0 when not enabled |
| mem_rdata | input | DATA_W (8) | Read data from memory |

## Verification
The bench applies several request patterns, and each one separates a different kind of fault. Isolated writes followed by read-back show whether each write lands at the registered address rather than at a stale or early one. Back-to-back alternating writes and reads to the same address show whether the strobe half-cycle and the capture edge are correct. A wrong edge returns the old byte. Idle gaps between requests show whether the address and strobe truly hold and whether a spurious response appears. The extreme addresses 0x0000 and 0xFFFF, together with a reset in the middle of traffic, show whether the full address width is used and whether every register is cleared.

// File: rtl/bus_cyc_pkg.sv
package bus_cyc_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned DATA_W_DEF = 8;
  typedef enum logic {STROBE_WRITE = 1'b0, STROBE_READ = 1'b1} strobe_e;
endpackage

// File: rtl/bcy_addr_phase.sv
module bcy_addr_phase #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              act_q,
  output logic              we_q,
  output logic [DATA_W-1:0] wdata_q
);
  // Falling edge closes the address phase.
  always_ff @(negedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      act_q   <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      act_q <= req_valid;
      if (req_valid) begin
        addr_q  <= req_addr;
        we_q    <= req_we;
        wdata_q <= req_wdata;
      end else begin
        we_q <= 1'b0;
      end
    end
  end

  p_hold_idle_r7: assert property (@(negedge clk) disable iff (rst)
    !req_valid |=> $stable(addr_q))
    else $error("p_hold_idle_r7");

  p_load_addr_r2: assert property (@(negedge clk) disable iff (rst)
    req_valid |=> (addr_q == $past(req_addr)))
    else $error("p_load_addr_r2");
endmodule

// File: rtl/bcy_strobe_ddr.sv
module bcy_strobe_ddr
  import bus_cyc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_cycle,
  output logic strobe
);
  logic q_rise;
  logic q_fall;

  // Rising-edge half: always idle at read level.
  always_ff @(posedge clk) begin
    q_rise <= STROBE_READ;
  end

  // Falling-edge half: level for the data phase.
  always_ff @(negedge clk) begin
    if (rst) q_fall <= STROBE_READ;
    else     q_fall <= req_level(wr_cycle);
  end

  function automatic logic req_level(input logic wr);
    return wr ? STROBE_WRITE : STROBE_READ;
  endfunction

  // Output mux selected by clock: high half -> rise register.
  assign strobe = (clk && !rst) ? q_rise : (rst ? STROBE_READ : q_fall);

  p_idle_first_half_r3: assert property (@(negedge clk) disable iff (rst)
    strobe == STROBE_READ)
    else $error("p_idle_first_half_r3");
endmodule

// File: rtl/bcy_wor_bus.sv
module bcy_wor_bus #(
  parameter int unsigned N_SRC = 1,
  parameter int unsigned W     = 8
) (
  input  logic [N_SRC-1:0]        src_en,
  input  logic [N_SRC-1:0][W-1:0] src_data,
  output logic [W-1:0]            bus
);
  logic [N_SRC:0][W-1:0] chain;
  assign chain[0] = '0;
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign chain[i+1] = chain[i] | (src_en[i] ? src_data[i] : '0);
  end
  assign bus = chain[N_SRC];
endmodule

// File: rtl/bcy_rd_capture.sv
module bcy_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic              we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  // Rising edge closes the data phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= act && !we;
      if (act && !we) rsp_data <= mem_rdata;
    end
  end

  p_read_returns_r6: assert property (@(posedge clk) disable iff (rst)
    (act && !we) |=> (rsp_valid && rsp_data == $past(mem_rdata)))
    else $error("p_read_returns_r6");

  p_no_spurious_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    !(act && !we) |=> (!rsp_valid && $stable(rsp_data)))
    else $error("p_no_spurious_rsp_r6");
endmodule

// File: rtl/two_phase_bus_if.sv
module two_phase_bus_if
  import bus_cyc_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rw_n,
  output logic              mem_oe,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic              act_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_cycle;

  assign req_ready = !rst;
  assign wr_cycle  = req_valid && req_we;

  bcy_addr_phase #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .addr_q(mem_addr), .act_q(act_q), .we_q(we_q), .wdata_q(wdata_q)
  );

  bcy_strobe_ddr u_strobe (
    .clk(clk), .rst(rst), .wr_cycle(wr_cycle), .strobe(mem_rw_n)
  );

  assign mem_oe = !clk && !rst && act_q && we_q;

  bcy_wor_bus #(.N_SRC(1), .W(DATA_W)) u_wbus (
    .src_en(mem_oe), .src_data(wdata_q), .bus(mem_wdata)
  );

  bcy_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .act(act_q), .we(we_q),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  p_oe_low_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    mem_oe |-> (mem_rw_n == STROBE_WRITE))
    else $error("p_oe_low_strobe_r5");

  p_wdata_default_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_oe |-> (mem_wdata == '0))
    else $error("p_wdata_default_r5");
endmodule

// File: tb/two_phase_bus_if_test.sv
`timescale 1ns/1ps
module two_phase_bus_if_test;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b1;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_rw_n, mem_oe;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] ext_mem [0:(1<<AW)-1];
  logic [DW-1:0] ref_mem [0:(1<<AW)-1];

  // reference state
  logic [AW-1:0] e_addr = '0;
  logic e_act = 0, e_we = 0, e_rv = 0;
  logic [DW-1:0] e_wd = '0, e_rd = '0;

  always #4 clk = ~clk;

  two_phase_bus_if uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_rw_n(mem_rw_n), .mem_oe(mem_oe), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = ext_mem[mem_addr];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // memory model: write near the end of the data phase
  always begin
    @(negedge clk);
    #3;
    if (mem_rw_n === 1'b0) ext_mem[mem_addr] = mem_wdata;
  end

  // reference model and checks in the data phase
  always begin
    @(negedge clk);
    if (rst) begin e_addr = '0; e_act = 0; e_we = 0; end
    else begin
      e_act = req_valid;
      e_we  = req_valid && req_we;
      if (req_valid) begin e_addr = req_addr; e_wd = req_wdata; end
    end
    #1;
    chk(mem_addr === e_addr, e_act ? "R2 addr" : "R7 addr hold", mem_addr, e_addr);
    chk(mem_rw_n === !e_we, e_act ? "R4 strobe" : "R7 strobe idle", mem_rw_n, !e_we);
    chk(mem_oe === e_we, "R5 oe", mem_oe, e_we);
    chk(mem_wdata === (e_we ? e_wd : 8'h00), "R5 wdata", mem_wdata, e_we ? e_wd : 8'h00);
  end

  // reference model and checks in the address phase
  always begin
    @(posedge clk);
    if (rst) begin e_rv = 0; e_rd = '0; end
    else begin
      e_rv = e_act && !e_we;
      if (e_rv) e_rd = ref_mem[e_addr];
      if (e_act && e_we) ref_mem[e_addr] = e_wd;
    end
    #1;
    chk(mem_rw_n === 1'b1, rst ? "R1 strobe" : "R3 strobe high", mem_rw_n, 1);
    chk(mem_oe === 1'b0 && mem_wdata === 8'h00, "R5 idle half", {mem_oe, mem_wdata}, 0);
    chk(mem_addr === e_addr, "R2 addr stable", mem_addr, e_addr);
    chk(rsp_valid === e_rv, rst ? "R1 rsp_valid" : "R6 rsp_valid", rsp_valid, e_rv);
    chk(rsp_data === e_rd, rst ? "R1 rsp_data" : "R6 rsp_data", rsp_data, e_rd);
    chk(req_ready === !rst, "R8 ready", req_ready, !rst);
  end

  task automatic cyc(input bit v, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = v; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      ext_mem[i] = DW'(i * 7 + 3);
      ref_mem[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_data === 8'h00 && rsp_valid === 1'b0, "R1 reset outputs", {rsp_valid, rsp_data}, 0);
    chk(mem_addr === '0, "R1 reset addr", mem_addr, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    // isolated writes and read-backs
    cyc(1, 1, 16'h0010, 8'hA5);
    cyc(0, 0, 16'h1234, 8'hFF);
    cyc(1, 1, 16'h0000, 8'h3C);
    cyc(1, 1, 16'hFFFF, 8'hC3);
    cyc(1, 0, 16'h0010, 8'h00);
    cyc(1, 0, 16'h0000, 8'h00);
    cyc(1, 0, 16'hFFFF, 8'h00);
    cyc(0, 1, 16'h0010, 8'h99);
    cyc(0, 1, 16'h0010, 8'h99);
    // back-to-back write then read of same address
    for (int k = 0; k < 40; k++) begin
      cyc(1, 1, AW'(16'h0200 + k), DW'(k * 13 + 1));
      cyc(1, 0, AW'(16'h0200 + k), 8'h00);
    end
    // mixed pattern with idle gaps
    for (int k = 0; k < 60; k++) begin
      cyc((k % 3) != 0, (k % 2) == 0, AW'(k * 1111), DW'(k ^ 8'h5A));
    end
    // reset in the middle of traffic
    cyc(1, 0, 16'h0200, 8'h00);
    rst = 1'b1;
    cyc(1, 1, 16'h0300, 8'h77);
    cyc(1, 1, 16'h0300, 8'h77);
    chk(rsp_valid === 1'b0 && rsp_data === 8'h00, "R1 mid reset", {rsp_valid, rsp_data}, 0);
    rst = 1'b0;
    cyc(1, 0, 16'h0300, 8'h00);
    cyc(1, 0, 16'h0010, 8'h00);
    cyc(0, 0, 16'h0000, 8'h00);
    cyc(0, 0, 16'h0000, 8'h00);
    // every write must have landed at its registered address
    for (int i = 0; i < (1<<AW); i++) begin
      if (ext_mem[i] !== ref_mem[i]) chk(0, "R8 memory image", ext_mem[i], ref_mem[i]);
    end
    chk(ext_mem[16'h0010] === 8'hA5, "R4 write landed", ext_mem[16'h0010], 8'hA5);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule